// File: doc/BRIEF.md
# Keyed Watchdog Timer with Posted Writes

This block is a watchdog timer that sits behind a small register port. The fast system clock runs the bus side. A slow tick strobe of about 32 kHz, synchronous to that clock, paces the timer. An up-counter advances once per prescaled tick. When it wraps past its all-ones value, the block pulses a reset request and reloads the counter from the load register.

Software must feed the watchdog by writing the trigger register. Each write has to carry a value different from the last one, for example a pattern alternating with its bitwise inverse. Run control is guarded: a two-word key written in the right order starts the timer, and a different two-word key stops it. Control and load settings can only be changed while the timer is stopped.

Every write is posted. The written word waits in a holding slot with its own pending flag until the slow tick domain takes it in. A status register exposes the four flags.

Top module: `kwdt_top`

## Requirements
- R1: After reset, every readable register (addresses 0 to 5) reads 0, the timer is stopped and `rst_req_o` is low.
- R2: A write to control (address 0), load (1), trigger (2) or key (3) sets status bit 0, 1, 2 or 3 respectively. The write takes effect and its bit clears on the second tick strobe after the write. The status register (address 4) reads 0 when nothing is pending.
- R3: Key word 0xBBBB followed by key word 0x4444 starts the timer and loads the counter from the load register.
- R4: Key word 0xAAAA followed by key word 0x5555 stops the timer, which then holds its count.
- R5: A key word that does not complete a sequence leaves the run state unchanged and clears the sequence tracker. 0xAAAA or 0xBBBB arms a new sequence instead; any other word disarms.
- R6: A control or load write that takes effect while the timer runs is dropped. The register keeps its old value, and its pending bit still clears.
- R7: While running, the counter rises by one per prescaled tick. Control bit 0 enables the prescaler and bits 4:2 hold a value p. When enabled, the counter advances on every 2^p-th tick; when disabled, on every tick.
- R8: A trigger write reloads the counter from the load register and restarts the prescaler, but only when the value differs from the one last held in the trigger register. The register reads back the last written value.
- R9: When a counting step starts from 0xFFFFFFFF, `rst_req_o` is high for exactly one clock cycle and the counter is reloaded from the load register.
- R10: Reads return control, load, trigger, 0 (key), status and counter for addresses 0 to 5. `rdata_o` is registered, one clock after the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Slow tick strobe, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for write and read |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- a write sets its pending flag on the next cycle;
- pending flags, run state and the counter change only on a tick strobe;
- the reset request never lasts more than one cycle and always follows a tick.

The bench scenarios cover the behaviours that depend on values. These are the key sequences, both valid and broken, the dropping of configuration while running, the compare-before-reload rule of the trigger, the prescale ratios, and the wrap from the all-ones count back to the load value.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;
  localparam int AW = 3;
  localparam logic [AW-1:0] A_CTRL  = 3'd0;
  localparam logic [AW-1:0] A_LOAD  = 3'd1;
  localparam logic [AW-1:0] A_TRIG  = 3'd2;
  localparam logic [AW-1:0] A_KEY   = 3'd3;
  localparam logic [AW-1:0] A_STAT  = 3'd4;
  localparam logic [AW-1:0] A_COUNT = 3'd5;
  localparam int NSLOT = 4;
  localparam logic [15:0] KEY_STOP1  = 16'hAAAA;
  localparam logic [15:0] KEY_STOP2  = 16'h5555;
  localparam logic [15:0] KEY_START1 = 16'hBBBB;
  localparam logic [15:0] KEY_START2 = 16'h4444;
  typedef enum logic [1:0] {K_IDLE, K_ARM_STOP, K_ARM_START} key_st_t;
endpackage

// File: rtl/kwdt_post.sv
// One posted-write slot: holds a word until the second tick after the write (R2).
module kwdt_post #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          pend_o,
  output logic          commit_o,
  output logic [DW-1:0] hold_o
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_o <= 1'b0;
      seen_q <= 1'b0;
      hold_o <= '0;
    end else if (wr_i) begin
      pend_o <= 1'b1;
      seen_q <= 1'b0;
      hold_o <= wdata_i;
    end else if (pend_o && tick_i) begin
      if (seen_q) pend_o <= 1'b0;
      else        seen_q <= 1'b1;
    end
  end

  assign commit_o = pend_o & tick_i & seen_q & ~wr_i;
endmodule

// File: rtl/kwdt_keyseq.sv
// Two-word key tracker for start (R3), stop (R4) and broken sequences (R5).
module kwdt_keyseq #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit_i,
  input  logic [DW-1:0] key_i,
  output logic          running_o,
  output logic          start_o
);
  import kwdt_pkg::*;
  key_st_t st_q;
  logic    stop_ev;

  assign start_o = commit_i && (st_q == K_ARM_START) && (key_i == DW'(KEY_START2));
  assign stop_ev = commit_i && (st_q == K_ARM_STOP)  && (key_i == DW'(KEY_STOP2));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= K_IDLE;
      running_o <= 1'b0;
    end else if (commit_i) begin
      if (start_o) begin
        running_o <= 1'b1;
        st_q      <= K_IDLE;
      end else if (stop_ev) begin
        running_o <= 1'b0;
        st_q      <= K_IDLE;
      end else if (key_i == DW'(KEY_STOP1)) begin
        st_q <= K_ARM_STOP;
      end else if (key_i == DW'(KEY_START1)) begin
        st_q <= K_ARM_START;
      end else begin
        st_q <= K_IDLE;
      end
    end
  end
endmodule

// File: rtl/kwdt_count.sv
// Prescaler and up-counter with wrap-reload and reset request (R7, R9).
module kwdt_count #(
  parameter int CW  = 32,
  parameter int PSW = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tick_i,
  input  logic           run_i,
  input  logic           pre_en_i,
  input  logic [PSW-1:0] ps_i,
  input  logic           load_i,
  input  logic [CW-1:0]  load_val_i,
  output logic [CW-1:0]  count_o,
  output logic           ovf_o
);
  localparam int PCW = (1 << PSW) - 1;
  logic [PCW-1:0] psc_q;
  logic [PCW-1:0] term;

  assign term = pre_en_i ? ((PCW'(1) << ps_i) - PCW'(1)) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      psc_q   <= '0;
      count_o <= '0;
      ovf_o   <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      if (load_i) begin
        count_o <= load_val_i;
        psc_q   <= '0;
      end else if (run_i && tick_i) begin
        if (psc_q == term) begin
          psc_q <= '0;
          if (&count_o) begin
            count_o <= load_val_i;
            ovf_o   <= 1'b1;
          end else begin
            count_o <= count_o + CW'(1);
          end
        end else begin
          psc_q <= psc_q + PCW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
  parameter int DW     = 32,
  parameter int PSW    = 3,
  parameter int PS_OFF = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   tick_i,
  input  logic                   wr_en_i,
  input  logic [kwdt_pkg::AW-1:0] addr_i,
  input  logic [DW-1:0]          wdata_i,
  output logic [DW-1:0]          rdata_o,
  output logic                   rst_req_o
);
  import kwdt_pkg::*;
  localparam int CTW = PS_OFF + PSW;

  logic [NSLOT-1:0] pend, commit;
  logic [DW-1:0]    hold [NSLOT];
  logic [CTW-1:0]   ctrl_q;
  logic [DW-1:0]    load_q, trig_q, count;
  logic             running, start_ev, trig_ev;

  // One posted slot per writable register; slot index equals address and status bit (R2).
  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    kwdt_post #(.DW(DW)) u_post (
      .clk(clk), .rst(rst), .tick_i(tick_i),
      .wr_i(wr_en_i && (addr_i == AW'(i))),
      .wdata_i(wdata_i),
      .pend_o(pend[i]), .commit_o(commit[i]), .hold_o(hold[i])
    );
  end

  kwdt_keyseq #(.DW(DW)) u_key (
    .clk(clk), .rst(rst),
    .commit_i(commit[A_KEY]), .key_i(hold[A_KEY]),
    .running_o(running), .start_o(start_ev)
  );

  // R8: reload only on a changed trigger value.
  assign trig_ev = commit[A_TRIG] && (hold[A_TRIG] != trig_q);

  // R6: configuration is dropped while running.
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      load_q <= '0;
      trig_q <= '0;
    end else begin
      if (commit[A_CTRL] && !running) ctrl_q <= hold[A_CTRL][CTW-1:0];
      if (commit[A_LOAD] && !running) load_q <= hold[A_LOAD];
      if (commit[A_TRIG])             trig_q <= hold[A_TRIG];
    end
  end

  kwdt_count #(.CW(DW), .PSW(PSW)) u_cnt (
    .clk(clk), .rst(rst), .tick_i(tick_i), .run_i(running),
    .pre_en_i(ctrl_q[0]), .ps_i(ctrl_q[PS_OFF +: PSW]),
    .load_i(start_ev || trig_ev), .load_val_i(load_q),
    .count_o(count), .ovf_o(rst_req_o)
  );

  // R10: registered read mux.
  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else begin
      case (addr_i)
        A_CTRL:  rdata_o <= DW'(ctrl_q);
        A_LOAD:  rdata_o <= load_q;
        A_TRIG:  rdata_o <= trig_q;
        A_STAT:  rdata_o <= DW'(pend);
        A_COUNT: rdata_o <= count;
        default: rdata_o <= '0;
      endcase
    end
  end
endmodule

// File: rtl/kwdt_chk.sv
module kwdt_chk #(
  parameter int DW = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    tick_i,
  input logic                    wr_en_i,
  input logic [kwdt_pkg::AW-1:0] addr_i,
  input logic                    rst_req_o,
  input logic [3:0]              pend,
  input logic [DW-1:0]           count,
  input logic                    running
);
  a_r2_ctrl_pend_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == kwdt_pkg::A_CTRL) |=> pend[0]);
  a_r2_key_pend_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == kwdt_pkg::A_KEY) |=> pend[3]);
  a_r2_pend_clear_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> ($countones(pend) >= $countones($past(pend))) || $past(rst));
  a_r7_count_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(count));
  a_r3_run_on_tick: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(running));
  a_r9_req_one_cycle: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o);
  a_r9_req_after_tick: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req_o) |-> $past(tick_i));
endmodule

bind kwdt_top kwdt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .tick_i(tick_i), .wr_en_i(wr_en_i), .addr_i(addr_i),
  .rst_req_o(rst_req_o), .pend(pend), .count(count), .running(running)
);

// File: tb/kwdt_top_bench.sv
module kwdt_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rst_req_o;

  int n_chk = 0;
  int n_fail = 0;
  int rst_hits = 0;
  bit done = 0;

  always #4 clk = ~clk;

  kwdt_top u_kwdt_top (.*);

  typedef struct packed {
    logic        we;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [3:0]  nt;
    logic [2:0]  ra;
    logic [31:0] ex;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VT [NV] = '{
    '{1'b1, 3'd1, 32'h100,      4'd0, 3'd4, 32'h2,        8'd2},  // R2 load pending
    '{1'b0, 3'd0, 32'h0,        4'd1, 3'd4, 32'h2,        8'd2},  // R2 still pending after 1 tick
    '{1'b0, 3'd0, 32'h0,        4'd1, 3'd4, 32'h0,        8'd2},  // R2 clear after 2 ticks
    '{1'b0, 3'd0, 32'h0,        4'd0, 3'd1, 32'h100,      8'd10}, // R10 load readback
    '{1'b1, 3'd0, 32'h5,        4'd2, 3'd0, 32'h5,        8'd10}, // R10 ctrl: en, p=1
    '{1'b1, 3'd3, 32'hBBBB,     4'd2, 3'd4, 32'h0,        8'd2},  // R2 key taken
    '{1'b1, 3'd3, 32'h4444,     4'd2, 3'd5, 32'h100,      8'd3},  // R3 start loads count
    '{1'b0, 3'd0, 32'h0,        4'd2, 3'd5, 32'h101,      8'd7},  // R7 divide by 2
    '{1'b1, 3'd1, 32'h500,      4'd2, 3'd1, 32'h100,      8'd6},  // R6 load dropped
    '{1'b1, 3'd0, 32'h0,        4'd2, 3'd0, 32'h5,        8'd6},  // R6 ctrl dropped
    '{1'b1, 3'd2, 32'h1234,     4'd2, 3'd5, 32'h100,      8'd8},  // R8 reload
    '{1'b1, 3'd2, 32'h1234,     4'd2, 3'd5, 32'h101,      8'd8},  // R8 same value, no reload
    '{1'b1, 3'd2, 32'hFFFFEDCB, 4'd2, 3'd5, 32'h100,      8'd8},  // R8 inverse reloads
    '{1'b0, 3'd0, 32'h0,        4'd0, 3'd2, 32'hFFFFEDCB, 8'd8},  // R8 trigger readback
    '{1'b1, 3'd3, 32'h5555,     4'd2, 3'd5, 32'h101,      8'd5},  // R5 lone second word
    '{1'b0, 3'd0, 32'h0,        4'd2, 3'd5, 32'h102,      8'd5},  // R5 still running
    '{1'b1, 3'd3, 32'hAAAA,     4'd2, 3'd5, 32'h103,      8'd5},  // R5 arm stop
    '{1'b1, 3'd3, 32'h1111,     4'd2, 3'd5, 32'h104,      8'd5},  // R5 bad word disarms
    '{1'b1, 3'd3, 32'h5555,     4'd2, 3'd5, 32'h105,      8'd5},  // R5 no stop
    '{1'b0, 3'd0, 32'h0,        4'd2, 3'd5, 32'h106,      8'd5},  // R5 still running
    '{1'b1, 3'd3, 32'hAAAA,     4'd2, 3'd5, 32'h107,      8'd4},  // R4 arm stop
    '{1'b1, 3'd3, 32'h5555,     4'd2, 3'd5, 32'h108,      8'd4},  // R4 stop
    '{1'b0, 3'd0, 32'h0,        4'd4, 3'd5, 32'h108,      8'd4},  // R4 count held
    '{1'b1, 3'd1, 32'hFFFFFFFD, 4'd2, 3'd1, 32'hFFFFFFFD, 8'd6},  // R6 load accepted when stopped
    '{1'b1, 3'd0, 32'h0,        4'd2, 3'd0, 32'h0,        8'd6},  // R6 ctrl accepted when stopped
    '{1'b1, 3'd3, 32'hBBBB,     4'd2, 3'd4, 32'h0,        8'd3},  // R3 arm start
    '{1'b1, 3'd3, 32'h4444,     4'd2, 3'd5, 32'hFFFFFFFD, 8'd3}   // R3 start
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_tick();
    @(negedge clk) tick_i = 1'b1;
    @(negedge clk) tick_i = 1'b0;
    if (rst_req_o) rst_hits++;
  endtask

  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk) begin wr_en_i = 1'b1; addr_i = a; wdata_i = d; end
    @(negedge clk) wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk) addr_i = a;
    @(negedge clk) d = rdata_o;
  endtask

  task automatic wr_commit(input logic [2:0] a, input logic [31:0] d);
    bus_wr(a, d);
    do_tick();
    do_tick();
  endtask

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    for (int a = 0; a < 6; a++) begin
      bus_rd(3'(a), v);
      check(v, 32'h0, "R1 reset register value");
    end
    check({31'b0, rst_req_o}, 32'h0, "R1 reset request low");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].we) bus_wr(VT[i].wa, VT[i].wd);
      for (int t = 0; t < int'(VT[i].nt); t++) do_tick();
      bus_rd(VT[i].ra, v);
      check(v, VT[i].ex, $sformatf("R%0d vector %0d", VT[i].req, i));
    end

    // R9 wrap from all ones
    rst_hits = 0;
    do_tick();
    do_tick();
    check(32'(rst_hits), 32'h0, "R9 no request before wrap");
    do_tick();
    check(32'(rst_hits), 32'h1, "R9 request at wrap");
    @(negedge clk);
    check({31'b0, rst_req_o}, 32'h0, "R9 request one cycle");
    bus_rd(3'd5, v);
    check(v, 32'hFFFFFFFD, "R9 reload after wrap");

    // R5 reversed start order does not start
    wr_commit(3'd3, 32'hAAAA);
    wr_commit(3'd3, 32'h5555);
    wr_commit(3'd3, 32'h4444);
    wr_commit(3'd3, 32'hBBBB);
    bus_rd(3'd5, v);
    repeat (3) do_tick();
    bus_rd(3'd5, v2);
    check(v2, v, "R5 reversed start ignored");

    // R7 divide by 4
    wr_commit(3'd0, 32'h9);
    wr_commit(3'd1, 32'h10);
    wr_commit(3'd3, 32'hBBBB);
    wr_commit(3'd3, 32'h4444);
    repeat (3) do_tick();
    bus_rd(3'd5, v);
    check(v, 32'h10, "R7 no step before 4th tick");
    do_tick();
    bus_rd(3'd5, v);
    check(v, 32'h11, "R7 step on 4th tick");
    bus_rd(3'd3, v);
    check(v, 32'h0, "R10 key reads zero");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule